// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block is the control and status register for one USB device endpoint, together with the decoder that turns an incoming token into a handshake decision. Software programs it through a single write port. Each write carries a data word and a strobe. Software reads the current contents back as one packed word.

The register holds the following fields:
- the endpoint number that the endpoint answers to;
- the endpoint type;
- a kind flag;
- a 2-bit status for each direction;
- a completion flag for each direction.

The address, type and kind fields are written directly. The status fields are toggle-only. A 1 in a written bit flips the stored bit, and a 0 leaves it alone. A completion flag is cleared by writing 0 to it. Writing 1 to a completion flag leaves it unchanged.

The transaction engine talks to the block over two paths. On the token path it presents each token: its endpoint number and its kind (OUT, IN or SETUP). The block answers one cycle later with IGNORE, STALL, NAK or ACCEPT, chosen from the status of the matching direction. On the completion path the engine pulses a completion for a finished transfer. The block then parks the affected direction at NAK, so that software must re-arm it, and raises that direction's completion flag. An isochronous endpoint keeps its status unchanged when a transfer completes.

Top module: `ep_ctl_reg`

## Requirements
- R1: After synchronous active-low reset, `rd_data` is all zero and `resp_valid` is 0. Both directions are therefore DISABLED, the address is 0 and the type is bulk.
- R2: A write sets the configuration fields directly: address from bits 3:0, type from bits 9:8 (00 bulk, 01 control, 10 isochronous, 11 interrupt) and kind from bit 10. The kind bit reads back but has no effect on responses or status updates.
- R3: The transmit status (bits 5:4) and receive status (bits 7:6) use the encoding 00 DISABLED, 01 STALL, 10 NAK, 11 VALID. In a write, each 1 bit flips the stored status bit and each 0 bit keeps it, and the new value reads back on the next cycle.
- R4: A completion pulse whose endpoint number equals the stored address, with kind IN or with kind SETUP on a control endpoint, sets the transmit status to NAK (10) and sets the transmit completion flag (bit 11).
- R5: A matching completion with kind OUT or SETUP sets the receive status to NAK (10) and sets the receive completion flag (bit 12).
- R6: On an isochronous endpoint, a matching completion leaves both status fields unchanged and still sets the completion flags.
- R7: A completion whose endpoint number differs from the stored address changes nothing.
- R8: When a software toggle and a hardware NAK update hit the same status field in the same cycle, the field becomes NAK.
- R9: Writing 0 to a completion flag bit clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R10: Token kind is encoded as 00 OUT, 01 IN, 10 SETUP and 11 reserved. A token addressed to the endpoint gives, one cycle later, `resp_valid`=1 and `resp_code` taken from the direction's status: IN uses the transmit status, and OUT and SETUP use the receive status. The codes are 00 IGNORE, 01 STALL, 10 NAK and 11 ACCEPT.
- R11: A token for another endpoint number, a reserved token kind, or no token gives `resp_valid`=0 and `resp_code`=00 on the next cycle.
- R12: A SETUP completion on a non-control endpoint leaves the transmit status and the transmit completion flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 13 | Software write word |
| rd_data | output | 13 | Current register contents |
| tok_valid | input | 1 | Token present this cycle |
| tok_ep | input | 4 | Endpoint number of the token |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| done_valid | input | 1 | Transfer completed successfully |
| done_ep | input | 4 | Endpoint number of the completed transfer |
| done_kind | input | 2 | Token kind of the completed transfer |
| resp_valid | output | 1 | Registered: the previous token was addressed here |
| resp_code | output | 2 | Registered decision: IGNORE, STALL, NAK or ACCEPT |

## Verification
A software toggle write and a hardware completion can land on the same status field in the same clock edge. Only one of them may win. The bench provokes this on purpose by raising the write strobe and a matching completion pulse together, with toggle bits set on the field that the completion targets. It then expects NAK in that field, while the other direction's toggle still applies. A randomized phase keeps producing such collisions, along with simultaneous flag clears. Every cycle is judged against a behavioural model, and the model applies the hardware update after the software one.

// File: rtl/ep_pkg.sv
// Package: shared encodings, field positions and types for the endpoint
// control register. Assumes a 4-bit endpoint number; all field positions
// are derived from that width.
package ep_pkg;

    localparam int EP_AW   = 4;            // endpoint number width
    localparam int ST_W    = 2;            // status field width
    localparam int F_TX    = EP_AW;        // transmit status low bit
    localparam int F_RX    = EP_AW + 2;    // receive status low bit
    localparam int F_TYPE  = EP_AW + 4;    // endpoint type low bit
    localparam int F_KIND  = EP_AW + 6;    // kind flag
    localparam int F_TXF   = EP_AW + 7;    // transmit completion flag
    localparam int F_RXF   = EP_AW + 8;    // receive completion flag
    localparam int REG_W   = EP_AW + 9;    // register word width
    localparam int N_DIR   = 2;            // index 0 transmit, 1 receive

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_VALID = 2'b11
    } ep_stat_e;

    typedef enum logic [1:0] {
        TY_BULK = 2'b00,
        TY_CTRL = 2'b01,
        TY_ISO  = 2'b10,
        TY_INTR = 2'b11
    } ep_type_e;

    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10,
        TK_RSVD  = 2'b11
    } tok_e;

    typedef enum logic [1:0] {
        RS_IGNORE = 2'b00,
        RS_STALL  = 2'b01,
        RS_NAK    = 2'b10,
        RS_ACCEPT = 2'b11
    } resp_e;

    typedef struct packed {
        logic [EP_AW-1:0] addr;
        logic [1:0]       ty;
        logic             kind;
    } ep_cfg_t;

    // Map a direction status to the handshake decision for that direction.
    function automatic logic [1:0] stat_to_resp(input logic [1:0] st);
        logic [1:0] r;
        case (st)
            ST_STALL: r = RS_STALL;
            ST_NAK:   r = RS_NAK;
            ST_VALID: r = RS_ACCEPT;
            default:  r = RS_IGNORE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ep_cfg_regs.sv
// Configuration fields: endpoint number, type and kind.
// Written directly by every software write; cleared by reset.
// Assumes the caller has already sliced the write word.
module ep_cfg_regs
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [EP_AW-1:0] wr_addr,
    input  logic [1:0]       wr_type,
    input  logic             wr_kind,
    output ep_cfg_t          cfg
);

    // Load the configuration word on a write, zero it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.addr <= wr_addr;
            cfg.ty   <= wr_type;
            cfg.kind <= wr_kind;
        end
    end

endmodule

// File: rtl/ep_event_dec.sv
// Completion event decoder: decides which direction a completed transfer
// updates, and whether status updates are suppressed (isochronous).
// Purely combinational; uses the stored configuration of this cycle.
module ep_event_dec
    import ep_pkg::*;
(
    input  logic             done_valid,
    input  logic [EP_AW-1:0] done_ep,
    input  logic [1:0]       done_kind,
    input  ep_cfg_t          cfg,
    output logic [N_DIR-1:0] evt,
    output logic             hold
);

    logic hit;

    // Qualify the completion by endpoint number and split it per direction.
    always_comb begin
        hit    = done_valid && (done_ep == cfg.addr);
        evt[0] = hit && ((done_kind == TK_IN) ||
                         (done_kind == TK_SETUP && cfg.ty == TY_CTRL));
        evt[1] = hit && ((done_kind == TK_OUT) || (done_kind == TK_SETUP));
        hold   = (cfg.ty == TY_ISO);
    end

endmodule

// File: rtl/ep_stat_field.sv
// One direction's status field and completion flag.
// Status: software toggles bits (1 flips, 0 keeps); a hardware event forces
// NAK unless held, and wins over a toggle in the same cycle.
// Flag: set by a hardware event, cleared by a software write of 0.
module ep_stat_field
    import ep_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr,
    input  logic [ST_W-1:0] sw_tgl,
    input  logic            sw_keep,
    input  logic            hw_evt,
    input  logic            hw_hold,
    output logic [ST_W-1:0] stat,
    output logic            flag
);

    // Status update: hardware NAK first, otherwise software toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= ST_OFF;
        end else if (hw_evt && !hw_hold) begin
            stat <= ST_NAK;
        end else if (sw_wr) begin
            stat <= stat ^ sw_tgl;
        end
    end

    // Completion flag: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hw_evt) begin
            flag <= 1'b1;
        end else if (sw_wr && !sw_keep) begin
            flag <= 1'b0;
        end
    end

    // R4/R5/R8: a non-held event leaves the field at NAK.
    p_hw_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt && !hw_hold) |=> (stat == ST_NAK));

    // R6: a held event without a toggle keeps the status.
    p_iso_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt && hw_hold && !(sw_wr && sw_tgl != '0)) |=> $stable(stat));

    // R3: a toggle with no event flips exactly the written bits.
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !hw_evt) |=> (stat == ($past(stat) ^ $past(sw_tgl))));

    // R9: an event always leaves the flag set.
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> flag);

endmodule

// File: rtl/ep_resp_dec.sv
// Token response decoder: for a token addressed to this endpoint, picks the
// direction's status and registers the handshake decision one cycle later.
// Unaddressed, reserved or absent tokens register IGNORE with valid low.
module ep_resp_dec
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [EP_AW-1:0] tok_ep,
    input  logic [1:0]       tok_kind,
    input  logic [EP_AW-1:0] cfg_addr,
    input  logic [ST_W-1:0]  tx_stat,
    input  logic [ST_W-1:0]  rx_stat,
    output logic             resp_valid,
    output logic [1:0]       resp_code
);

    logic            hit;
    logic [ST_W-1:0] sel;

    // Qualify the token and select the status of its direction.
    always_comb begin
        hit = tok_valid && (tok_ep == cfg_addr) && (tok_kind != TK_RSVD);
        sel = (tok_kind == TK_IN) ? tx_stat : rx_stat;
    end

    // Register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RS_IGNORE;
        end else begin
            resp_valid <= hit;
            resp_code  <= hit ? stat_to_resp(sel) : RS_IGNORE;
        end
    end

    // R11: no token means no response next cycle.
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

    // R11: a token for another endpoint is not answered.
    p_other_ep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ep != cfg_addr) |=> (!resp_valid && resp_code == RS_IGNORE));

endmodule

// File: rtl/ep_ctl_reg.sv
// Top: USB endpoint control/status register with response decoder.
// Assumes one completion and one token per cycle at most, synchronous
// active-low reset, and software writes presented as a full word.
module ep_ctl_reg
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             tok_valid,
    input  logic [EP_AW-1:0] tok_ep,
    input  logic [1:0]       tok_kind,
    input  logic             done_valid,
    input  logic [EP_AW-1:0] done_ep,
    input  logic [1:0]       done_kind,
    output logic             resp_valid,
    output logic [1:0]       resp_code
);

    localparam int DIR_LO [N_DIR] = '{F_TX, F_RX};
    localparam int DIR_FL [N_DIR] = '{F_TXF, F_RXF};

    ep_cfg_t                     cfg;
    logic [N_DIR-1:0]            evt;
    logic                        hold;
    logic [N_DIR-1:0][ST_W-1:0]  stat;
    logic [N_DIR-1:0]            flag;

    ep_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_data[EP_AW-1:0]),
        .wr_type (wr_data[F_TYPE+1:F_TYPE]),
        .wr_kind (wr_data[F_KIND]),
        .cfg     (cfg)
    );

    ep_event_dec u_evt (
        .done_valid (done_valid),
        .done_ep    (done_ep),
        .done_kind  (done_kind),
        .cfg        (cfg),
        .evt        (evt),
        .hold       (hold)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ep_stat_field u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_wr   (wr_en),
            .sw_tgl  (wr_data[DIR_LO[d]+ST_W-1:DIR_LO[d]]),
            .sw_keep (wr_data[DIR_FL[d]]),
            .hw_evt  (evt[d]),
            .hw_hold (hold),
            .stat    (stat[d]),
            .flag    (flag[d])
        );
    end

    ep_resp_dec u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_ep     (tok_ep),
        .tok_kind   (tok_kind),
        .cfg_addr   (cfg.addr),
        .tx_stat    (stat[0]),
        .rx_stat    (stat[1]),
        .resp_valid (resp_valid),
        .resp_code  (resp_code)
    );

    // Pack the read-back word.
    always_comb begin
        rd_data = {flag[1], flag[0], cfg.kind, cfg.ty, stat[1], stat[0], cfg.addr};
    end

    // R7: a completion for another endpoint leaves the statuses alone.
    p_other_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ep != cfg.addr && !wr_en) |=> $stable(stat));

    // R12: a SETUP completion on a non-control endpoint spares the transmit side.
    p_setup_tx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_kind == TK_SETUP && cfg.ty != TY_CTRL && !wr_en)
        |=> $stable(stat[0]));

endmodule

// File: tb/sim_ep_ctl_reg.sv
// Bench: directed and randomized stimulus, compared each cycle against a
// behavioural model, plus literal checks on key scenarios.
`timescale 1ns/1ps
module sim_ep_ctl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] wr_data = '0;
    logic [12:0] rd_data;
    logic        tok_valid = 1'b0;
    logic [3:0]  tok_ep = '0;
    logic [1:0]  tok_kind = '0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_ep = '0;
    logic [1:0]  done_kind = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;

    always #10 clk = ~clk;

    ep_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_kind(tok_kind),
        .done_valid(done_valid), .done_ep(done_ep), .done_kind(done_kind),
        .resp_valid(resp_valid), .resp_code(resp_code)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    int m_addr = 0, m_tx = 0, m_rx = 0, m_ty = 0, m_kind = 0, m_txf = 0, m_rxf = 0;
    int m_rv = 0, m_rc = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_rd();
        return m_addr | (m_tx << 4) | (m_rx << 6) | (m_ty << 8) |
               (m_kind << 10) | (m_txf << 11) | (m_rxf << 12);
    endfunction

    // Advance one clock: model next state from current inputs, then compare.
    task automatic tick();
        int n_addr = m_addr, n_tx = m_tx, n_rx = m_rx, n_ty = m_ty;
        int n_kind = m_kind, n_txf = m_txf, n_rxf = m_rxf, n_rv, n_rc;
        if (wr_en) begin
            n_addr = int'(wr_data[3:0]);
            n_ty   = int'(wr_data[9:8]);
            n_kind = int'(wr_data[10]);
            n_tx   = m_tx ^ int'(wr_data[5:4]);
            n_rx   = m_rx ^ int'(wr_data[7:6]);
            if (!wr_data[11]) n_txf = 0;
            if (!wr_data[12]) n_rxf = 0;
        end
        if (done_valid && int'(done_ep) == m_addr) begin
            if (done_kind == 2'd1 || (done_kind == 2'd2 && m_ty == 1)) begin
                n_txf = 1;
                if (m_ty != 2) n_tx = 2;
            end
            if (done_kind == 2'd0 || done_kind == 2'd2) begin
                n_rxf = 1;
                if (m_ty != 2) n_rx = 2;
            end
        end
        n_rv = (tok_valid && int'(tok_ep) == m_addr && tok_kind != 2'd3) ? 1 : 0;
        n_rc = (n_rv == 1) ? ((tok_kind == 2'd1) ? m_tx : m_rx) : 0;
        @(posedge clk);
        @(negedge clk);
        m_addr = n_addr; m_tx = n_tx; m_rx = n_rx; m_ty = n_ty;
        m_kind = n_kind; m_txf = n_txf; m_rxf = n_rxf; m_rv = n_rv; m_rc = n_rc;
        check(cur_req, int'(rd_data), model_rd());
        check(cur_req, int'(resp_valid), m_rv);
        check(cur_req, int'(resp_code), m_rc);
    endtask

    task automatic idle();
        wr_en = 1'b0; tok_valid = 1'b0; done_valid = 1'b0;
    endtask

    task automatic do_wr(input int d);
        wr_en = 1'b1; wr_data = 13'(d); tick(); idle();
    endtask

    task automatic do_tok(input int ep, input int kind);
        tok_valid = 1'b1; tok_ep = 4'(ep); tok_kind = 2'(kind); tick(); idle();
    endtask

    task automatic do_done(input int ep, input int kind);
        done_valid = 1'b1; done_ep = 4'(ep); done_kind = 2'(kind); tick(); idle();
    endtask

    // Config word that keeps flags and toggles nothing.
    function automatic int cfg_word(input int addr, input int ty, input int kind);
        return addr | (ty << 8) | (kind << 10) | (1 << 11) | (1 << 12);
    endfunction

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", int'(rd_data), 0);
        check("R1", int'(resp_valid), 0);
        rst_n = 1'b1;
        tick();

        // R2/R3: address 5, bulk, both directions toggled to VALID.
        cur_req = "R2";
        do_wr(13'h18F5);
        check("R2", int'(rd_data), 13'h00F5);

        // R10: addressed tokens answered from the right direction.
        cur_req = "R10";
        do_tok(5, 1);
        check("R10", int'(resp_code), 3);
        do_tok(5, 0);
        check("R10", int'(resp_valid), 1);

        // R11: other endpoint and reserved kind.
        cur_req = "R11";
        do_tok(3, 1);
        check("R11", int'(resp_valid), 0);
        do_tok(5, 3);
        check("R11", int'(resp_valid), 0);

        // R3: toggle transmit VALID->NAK->STALL->VALID.
        cur_req = "R3";
        do_wr(cfg_word(5, 0, 0) | (1 << 4));
        check("R3", int'(rd_data[5:4]), 2);
        do_tok(5, 1);
        check("R10", int'(resp_code), 2);
        do_wr(cfg_word(5, 0, 0) | (3 << 4));
        check("R3", int'(rd_data[5:4]), 1);
        do_tok(5, 1);
        check("R10", int'(resp_code), 1);
        do_wr(cfg_word(5, 0, 0) | (2 << 4));
        check("R3", int'(rd_data[5:4]), 3);

        // R4: IN completion parks transmit at NAK.
        cur_req = "R4";
        do_done(5, 1);
        check("R4", int'(rd_data[5:4]), 2);
        check("R4", int'(rd_data[11]), 1);

        // R7: completion for another endpoint.
        cur_req = "R7";
        do_done(7, 0);
        check("R7", int'(rd_data[7:6]), 3);

        // R5: OUT completion.
        cur_req = "R5";
        do_done(5, 0);
        check("R5", int'(rd_data[7:6]), 2);
        check("R5", int'(rd_data[12]), 1);

        // R9: write 1 keeps flags, write 0 clears.
        cur_req = "R9";
        do_wr(cfg_word(5, 0, 0));
        check("R9", int'(rd_data[12:11]), 3);
        do_wr(5);
        check("R9", int'(rd_data[12:11]), 0);

        // R8: toggle and completion collide on the transmit field.
        cur_req = "R8";
        do_wr(cfg_word(5, 0, 0) | (1 << 4));
        wr_en = 1'b1; wr_data = 13'(5 | (1 << 4) | (1 << 6));
        done_valid = 1'b1; done_ep = 4'd5; done_kind = 2'd1;
        tick(); idle();
        check("R8", int'(rd_data[5:4]), 2);
        check("R8", int'(rd_data[11]), 1);

        // R4/R5: SETUP on control hits both directions.
        cur_req = "R4";
        do_wr(cfg_word(5, 1, 0) | (1 << 4) | (1 << 6));
        do_done(5, 2);
        check("R4", int'(rd_data[7:4]), 4'hA);

        // R12: SETUP on bulk spares transmit.
        cur_req = "R12";
        do_wr(5 | (1 << 4) | (3 << 6));
        do_done(5, 2);
        check("R12", int'(rd_data[5:4]), 3);
        check("R12", int'(rd_data[11]), 0);
        check("R12", int'(rd_data[7:6]), 2);

        // R6: isochronous keeps statuses, sets flags.
        cur_req = "R6";
        do_wr(5 | (2 << 8) | (1 << 6));
        do_done(5, 1);
        do_done(5, 0);
        check("R6", int'(rd_data[7:4]), 4'hF);
        check("R6", int'(rd_data[12:11]), 3);

        // R10: disabled direction answered IGNORE with valid high.
        cur_req = "R10";
        do_wr(cfg_word(5, 3, 1) | (3 << 4));
        do_tok(5, 1);
        check("R10", int'(resp_valid), 1);
        check("R10", int'(resp_code), 0);

        // Randomized mix with frequent collisions (R3 R4 R5 R8 R9 R10).
        cur_req = "R8 random";
        for (int i = 0; i < 2000; i++) begin
            int r = int'($urandom);
            wr_en      = (r[1:0] == 2'b00);
            wr_data    = 13'($urandom);
            if (r[4:2] != 3'b000) wr_data[3:0] = 4'd5;
            tok_valid  = r[5];
            tok_ep     = r[6] ? 4'd5 : 4'd6;
            tok_kind   = 2'(r[8:7]);
            done_valid = r[9];
            done_ep    = r[10] ? 4'd5 : 4'(r[14:11]);
            done_kind  = 2'(r[16:15]);
            tick();
        end
        idle();
        tick();
        finish_up();
    end

endmodule